// File: doc/BRIEF.md
# Caption Line Data Scheduler

This block holds the caption bytes that a host writes and presents them, two bytes at a time, on the caption lines of each video frame. The video timing generator supplies the line number and the field. Two enable bits choose which caption lines are used. The first caption line is line 21 of field 0, and the second is line 284 of field 1. On every enabled caption line the block outputs a 16-bit word with a valid flag. It also raises a blanking request, so that the active video on that line is replaced by blanking level.

Host bytes build up in a collection register. When a group is complete, it moves to a staging register. The staged data reaches the active register only on a line that is not a caption line, so the word on a caption line never changes while that line is in progress. The active data is sent again in every frame until the line is disabled. The block does not compute parity: every bit, the top bit of each byte included, is passed through exactly as written. Waveform synthesis is done downstream.

Top module: `cc_line_sched`

## Requirements
- R1: When `en_a_i` is 1, `field_i` is 0 and `line_cnt_i` equals 21, `cc_valid_o` is 1 and `cc_word_o` holds group byte 0 in bits 7:0 and byte 1 in bits 15:8. On any line other than 21 or 284, `cc_valid_o` is 0.
- R2: When `en_b_i` is 1, `field_i` is 1 and `line_cnt_i` equals 284, `cc_valid_o` is 1 and `cc_word_o` holds byte 2 in bits 7:0 and byte 3 in bits 15:8.
- R3: When both enables are 1, a group is four written bytes in the order byte 0 to byte 3. The first pair goes to line 21 and the second pair to line 284.
- R4: When only one enable is 1, two written bytes complete a group. They update only the half of that line (bytes 0–1 for line 21, bytes 2–3 for line 284), and the other half keeps its value.
- R5: The block does not alter parity bits. Bit 7 of every byte appears on the output unchanged.
- R6: Committed data is output again on its line in every frame for as long as the line stays enabled.
- R7: `blank_o` is 1 on every caption line whose enable is set.
- R8: When a line's enable is 0, that line has `cc_valid_o` = 0, `blank_o` = 0 and `cc_word_o` = 0. While either output flag is 0, the word is 0.
- R9: A group completed before the previous group has been committed replaces it. There is no queueing.
- R10: Staged data is committed only while `line_cnt_i` is neither 21 nor 284. The word stays stable throughout a caption line.
- R11: A group that is only partly written never reaches the output.
- R12: With both enables at 0, writes still form four-byte groups. Any change of the enable pair restarts the byte position at the first byte of the group. If a write arrives in the same cycle as the change, that write is stored as the first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_a_i | input | 1 | Enable for caption line 21 |
| en_b_i | input | 1 | Enable for caption line 284 |
| wr_en_i | input | 1 | Host byte write strobe |
| wr_data_i | input | 8 | Host byte |
| line_cnt_i | input | 10 | Current line number from the timing generator |
| field_i | input | 1 | Current field (0 or 1) |
| cc_word_o | output | 16 | Caption word for the current line |
| cc_valid_o | output | 1 | The caption word applies to this line |
| blank_o | output | 1 | Force active video to blanking level |

## Verification
Four-byte groups are written with both lines enabled and compared with two-byte groups written with one line enabled. This separates byte placement from half-word masking. Bytes with their top bit set show whether parity bits pass through unchanged. Two groups are written back to back during a caption line: this shows whether a commit is held off until the line ends and whether the later group replaces the earlier one. A group left half written, followed by writes with the enables off and then a change of enables, checks that partial groups stay hidden and that the byte position restarts on an enable change.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned GRP_BYTES  = 4;
  localparam int unsigned HALF_BYTES = GRP_BYTES / 2;
  localparam int unsigned HALF_W     = BYTE_W * HALF_BYTES;
  localparam int unsigned GRP_W      = BYTE_W * GRP_BYTES;
  localparam int unsigned PTR_W      = $clog2(GRP_BYTES);

  typedef logic [BYTE_W-1:0] cc_byte_t;
  typedef logic [GRP_W-1:0]  cc_group_t;
  typedef logic [HALF_W-1:0] cc_half_t;
  typedef logic [1:0]        cc_lines_t;  // bit0 = line A, bit1 = line B
endpackage

// File: rtl/cc_line_match.sv
module cc_line_match #(
  parameter int unsigned LINE_W = 10,
  parameter int unsigned LINE_A = 21,
  parameter int unsigned LINE_B = 284
) (
  input  logic [LINE_W-1:0] line_cnt_i,
  input  logic              field_i,
  output logic              on_a_o,
  output logic              on_b_o,
  output logic              hold_o
);
  logic is_a, is_b;

  assign is_a   = (line_cnt_i == LINE_W'(LINE_A));
  assign is_b   = (line_cnt_i == LINE_W'(LINE_B));
  assign on_a_o = is_a && !field_i;
  assign on_b_o = is_b &&  field_i;
  // commit is blocked on either caption line number, whatever the field
  assign hold_o = is_a || is_b;
endmodule

// File: rtl/cc_byte_collect.sv
module cc_byte_collect
  import cc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  cc_lines_t en_i,
  input  logic      wr_en_i,
  input  cc_byte_t  wr_data_i,
  output logic      done_o,
  output cc_lines_t mask_o,
  output cc_group_t group_o
);
  logic [PTR_W-1:0] ptr_q, ptr_eff, idx;
  cc_lines_t        en_q;
  cc_byte_t         shadow_q [GRP_BYTES];
  cc_byte_t         shadow_d [GRP_BYTES];
  logic             full_grp, last;

  assign full_grp = (en_i == 2'b00) || (en_i == 2'b11);
  assign ptr_eff  = (en_i != en_q) ? '0 : ptr_q;
  assign last     = full_grp ? (ptr_eff == PTR_W'(GRP_BYTES - 1))
                             : (ptr_eff == PTR_W'(HALF_BYTES - 1));
  // line-B-only writes land in the upper half
  assign idx      = (en_i == 2'b10) ? ptr_eff + PTR_W'(HALF_BYTES) : ptr_eff;
  assign done_o   = wr_en_i && last;
  assign mask_o   = full_grp ? 2'b11 : en_i;

  for (genvar b = 0; b < GRP_BYTES; b++) begin : g_byte
    assign shadow_d[b] = (wr_en_i && idx == PTR_W'(b)) ? wr_data_i : shadow_q[b];
    assign group_o[b*BYTE_W +: BYTE_W] = shadow_d[b];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) shadow_q[b] <= '0;
      else         shadow_q[b] <= shadow_d[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      en_q  <= '0;
    end else begin
      en_q <= en_i;
      if (wr_en_i) ptr_q <= last ? '0 : ptr_eff + 1'b1;
      else         ptr_q <= ptr_eff;
    end
  end
endmodule

// File: rtl/cc_commit.sv
module cc_commit
  import cc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      done_i,
  input  cc_lines_t mask_i,
  input  cc_group_t group_i,
  input  logic      hold_i,
  output cc_group_t active_o
);
  for (genvar h = 0; h < 2; h++) begin : g_half
    cc_half_t stage_q, act_q;
    logic     pend_q;

    assign active_o[h*HALF_W +: HALF_W] = act_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q <= '0;
        act_q   <= '0;
        pend_q  <= 1'b0;
      end else begin
        if (!hold_i && pend_q) act_q <= stage_q;
        // a new group replaces any uncommitted one
        if (done_i && mask_i[h]) stage_q <= group_i[h*HALF_W +: HALF_W];
        pend_q <= (hold_i && pend_q) || (done_i && mask_i[h]);
      end
    end
  end
endmodule

// File: rtl/cc_line_sched.sv
module cc_line_sched
  import cc_pkg::*;
#(
  parameter int unsigned LINE_W = 10,
  parameter int unsigned LINE_A = 21,
  parameter int unsigned LINE_B = 284
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_a_i,
  input  logic              en_b_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_data_i,
  input  logic [LINE_W-1:0] line_cnt_i,
  input  logic              field_i,
  output logic [15:0]       cc_word_o,
  output logic              cc_valid_o,
  output logic              blank_o
);
  cc_lines_t en, mask;
  cc_group_t group, active;
  logic      on_a, on_b, hold, done, sel_a, sel_b;

  assign en = {en_b_i, en_a_i};

  cc_line_match #(.LINE_W(LINE_W), .LINE_A(LINE_A), .LINE_B(LINE_B)) match_i (
    .line_cnt_i(line_cnt_i), .field_i(field_i),
    .on_a_o(on_a), .on_b_o(on_b), .hold_o(hold)
  );

  cc_byte_collect collect_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .done_o(done), .mask_o(mask), .group_o(group)
  );

  cc_commit commit_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done), .mask_i(mask),
    .group_i(group), .hold_i(hold), .active_o(active)
  );

  assign sel_a      = on_a && en_a_i;
  assign sel_b      = on_b && en_b_i;
  assign cc_valid_o = sel_a || sel_b;
  assign blank_o    = sel_a || sel_b;
  assign cc_word_o  = sel_a ? active[HALF_W-1:0] :
                      sel_b ? active[GRP_W-1:HALF_W] : '0;
endmodule

// File: rtl/cc_line_sched_chk.sv
module cc_line_sched_chk #(
  parameter int unsigned LINE_W = 10,
  parameter int unsigned LINE_A = 21,
  parameter int unsigned LINE_B = 284
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_a_i,
  input logic              en_b_i,
  input logic [LINE_W-1:0] line_cnt_i,
  input logic              field_i,
  input logic [15:0]       cc_word_o,
  input logic              cc_valid_o,
  input logic              blank_o
);
  logic cap_line;
  assign cap_line = (line_cnt_i == LINE_W'(LINE_A)) || (line_cnt_i == LINE_W'(LINE_B));

  // R1
  valid_on_cap_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cc_valid_o |-> cap_line);

  // R7
  blank_on_enabled_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_a_i && !field_i && line_cnt_i == LINE_W'(LINE_A)) |-> blank_o);

  // R8
  quiet_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_a_i && !en_b_i) |-> (!cc_valid_o && !blank_o));

  // R8
  word_zero_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cc_valid_o |-> (cc_word_o == 16'h0));

  // R10
  word_stable_in_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_line && $stable(line_cnt_i) && $stable(field_i) && $stable(en_a_i)
     && $stable(en_b_i)) |=> (!$stable(line_cnt_i) || !$stable(field_i)
     || !$stable(en_a_i) || !$stable(en_b_i) || $stable(cc_word_o)));
endmodule

bind cc_line_sched cc_line_sched_chk #(.LINE_W(LINE_W), .LINE_A(LINE_A), .LINE_B(LINE_B)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_a_i(en_a_i), .en_b_i(en_b_i),
  .line_cnt_i(line_cnt_i), .field_i(field_i),
  .cc_word_o(cc_word_o), .cc_valid_o(cc_valid_o), .blank_o(blank_o)
);

// File: tb/cc_line_sched_tb_top.sv
module cc_line_sched_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_a = 1'b0, en_b = 1'b0, wr_en = 1'b0, field = 1'b0;
  logic [7:0] wr_data = 8'h0;
  logic [9:0] line = 10'd0;
  logic [15:0] word;
  logic       valid, blank;
  int         checks = 0, fails = 0;
  bit         done_flag = 1'b0;

  always #4 clk = ~clk;

  cc_line_sched dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_a_i(en_a), .en_b_i(en_b),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .line_cnt_i(line), .field_i(field),
    .cc_word_o(word), .cc_valid_o(valid), .blank_o(blank)
  );

  // reference model
  int   m_ptr = 0;
  int   m_en_prev = 0;
  logic [7:0] m_sh [4];
  logic [7:0] m_stage [4];
  logic [7:0] m_act [4];
  bit   m_pend [2];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ptr = 0; m_en_prev = 0;
      for (int i = 0; i < 4; i++) begin m_sh[i] = 0; m_stage[i] = 0; m_act[i] = 0; end
      m_pend[0] = 0; m_pend[1] = 0;
    end else begin
      int en_now, size, base;
      bit hold, a_line, b_line;
      logic [15:0] e_word;
      en_now = {en_b, en_a};
      if (en_now != m_en_prev) m_ptr = 0;
      m_en_prev = en_now;
      hold = (line == 10'd21) || (line == 10'd284);
      if (!hold)
        for (int h = 0; h < 2; h++)
          if (m_pend[h]) begin
            m_act[2*h] = m_stage[2*h]; m_act[2*h+1] = m_stage[2*h+1]; m_pend[h] = 0;
          end
      if (wr_en) begin
        size = (en_now == 1 || en_now == 2) ? 2 : 4;
        base = (en_now == 2) ? 2 : 0;
        m_sh[base + m_ptr] = wr_data;
        m_ptr++;
        if (m_ptr == size) begin
          m_ptr = 0;
          for (int h = 0; h < 2; h++)
            if (size == 4 || en_now[h]) begin
              m_stage[2*h] = m_sh[2*h]; m_stage[2*h+1] = m_sh[2*h+1]; m_pend[h] = 1;
            end
        end
      end
      #2;
      a_line = en_a && !field && line == 10'd21;
      b_line = en_b &&  field && line == 10'd284;
      e_word = a_line ? {m_act[1], m_act[0]} : b_line ? {m_act[3], m_act[2]} : 16'h0;
      if (a_line)      check("R1 per-cycle", {valid, blank, word}, {2'b11, e_word});
      else if (b_line) check("R2 per-cycle", {valid, blank, word}, {2'b11, e_word});
      else             check("R8 per-cycle", {valid, blank, word}, {2'b00, e_word});
    end
  end

  task automatic wr(logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic go_line(logic f, int l, int n);
    @(negedge clk); field = f; line = 10'(l);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_en(logic a, logic b);
    @(negedge clk); en_a = a; en_b = b;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset", {valid, blank, word}, 18'h0);
    rst_n = 1'b1;
    go_line(0, 10, 2);
    // R12/R3: four-byte group with lines disabled, byte 3 has bit 7 set
    wr(8'h11); wr(8'h22); wr(8'h33); wr(8'hC4);
    set_en(1, 1);
    go_line(0, 21, 3);
    check("R3 line21 word", word, 16'h2211);
    check("R7 line21 blank", blank, 1'b1);
    go_line(1, 284, 3);
    check("R5 line284 parity bit kept", word, 16'hC433);
    go_line(0, 5, 3);
    go_line(0, 21, 2);
    check("R6 second frame", word, 16'h2211);
    go_line(0, 30, 2);
    // R4: line A only, two-byte update
    set_en(1, 0);
    wr(8'h55); wr(8'hAA);
    go_line(0, 21, 3);
    check("R4 line21 updated", word, 16'hAA55);
    go_line(1, 284, 3);
    check("R8 line284 disabled", {valid, blank}, 2'b00);
    set_en(1, 1);
    go_line(1, 284, 2);
    check("R4 other half unchanged", word, 16'hC433);
    // R9/R10: two groups during line 21
    go_line(0, 21, 1);
    wr(8'h01); wr(8'h02); wr(8'h03); wr(8'h04);
    wr(8'h05); wr(8'h06); wr(8'h07); wr(8'h08);
    check("R10 held during line", word, 16'hAA55);
    go_line(0, 22, 2);
    go_line(1, 284, 2);
    check("R9 newest group line284", word, 16'h0807);
    go_line(0, 21, 2);
    check("R9 newest group line21", word, 16'h0605);
    // R11: half-written group hidden
    go_line(0, 40, 1);
    wr(8'h9A); wr(8'hBC);
    go_line(0, 21, 2);
    check("R11 partial hidden a", word, 16'h0605);
    go_line(1, 284, 2);
    check("R11 partial hidden b", word, 16'h0807);
    go_line(1, 300, 1);
    wr(8'hDE); wr(8'hF0);
    go_line(0, 21, 2);
    check("R11 completed a", word, 16'hBC9A);
    go_line(1, 284, 2);
    check("R11 completed b", word, 16'hF0DE);
    // R8/R12: disable, write, then enable line B only
    set_en(0, 0);
    go_line(0, 21, 2);
    check("R8 off no flags", {valid, blank, word}, 18'h0);
    go_line(0, 50, 1);
    wr(8'h12); wr(8'h34); wr(8'h56); wr(8'h78);
    set_en(0, 1);
    go_line(1, 284, 2);
    check("R12 group while off", word, 16'h7856);
    go_line(0, 21, 2);
    check("R2 line21 off with only B", valid, 1'b0);
    // R12: pointer restart on enable change after a stray byte
    go_line(0, 60, 1);
    wr(8'hEE);
    set_en(1, 0);
    wr(8'h61); wr(8'h62);
    go_line(0, 21, 2);
    check("R12 pointer restart", word, 16'h6261);
    go_line(0, 61, 2);
    done_flag = 1'b1;
    finish_run();
  end
endmodule